// File: doc/BRIEF.md
# Two-Level Masked Interrupt Aggregator

This block gathers interrupt requests from three sources into one interrupt line. The first source is a top-level pending word. The second is a 32-bit word of events from a USB device core. The third is a DMA completion word. Each source has its own pending word and mask word, and software sets, clears and masks bits through a simple register port. The two halves of the core word and the whole DMA word are each reduced to one summary bit, and these summary bits appear in the top-level word. A fourth set of registers, for general-purpose I/O, has the same set/clear/mask layout but only stores values and never reaches the output.

The interrupt line is driven from the top-level word after masking. A configuration bit chooses its polarity. A gate that depends on power state also controls the line. When the power-on input rises, the gate closes at once. It opens again after a programmable number of cycles, but only if power is still present at that moment.

Hardware event inputs drive one top-level bit at a time, selected by index, and follow the given level.

Top module: `irq_aggregator`

## Requirements
- R1: After reset the top-level mask reads 0xFFFFFFFF. Every other register reads zero and `irq` is low.
- R2: Register addresses:
  - Top-level: 0 view, 1 set, 2 clear, 3 mask.
  - Core: 4 view, 5 set, 6 clear, 7 mask.
  - DMA: 8 view, 9 set, 10 clear, 11 mask.
  - General-purpose: 12 view, 13 set, 14 clear, 15 mask.
  - Configuration: 16.

  A set write ORs the data into the pending word. A clear write clears the bits that are written as one. A mask write replaces the mask. Writes to a view address are ignored. Reads of the view, set or clear address return the pending word. Any other address reads zero.
- R3: Top-level bit 9 reads 1 when any core bit in 15:0 is both pending and unmasked. Bit 8 does the same for core bits 31:16. Otherwise each of these bits reads 0, whatever software writes to it.
- R4: Top-level bit 24 reads 1 when any DMA bit is both pending and unmasked, and reads 0 otherwise.
- R5: When configuration bit 17 is 1, `irq` is high exactly when the gate is open and at least one top-level bit is both pending and unmasked.
- R6: When configuration bit 17 is 0, `irq` is high exactly when the gate is open and no top-level bit is both pending and unmasked.
- R7: A rising edge on `pwr_on` closes the gate on the next clock. The gate opens `GATE_DELAY` cycles after that, if `pwr_on` is still high then.
- R8: If `pwr_on` is low when the delay ends, the gate stays closed. A falling `pwr_on` never changes the gate.
- R9: When `evt_valid` is high, top-level pending bit `evt_idx` takes the value of `evt_level`.
- R10: If a hardware event and a software set or clear write hit the same top-level bit in the same cycle, the hardware event decides the bit.
- R11: The general-purpose pending and mask words can be read back but have no effect on `irq` or on the top-level word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 5 | Read address |
| rd_data | output | 32 | Read data, combinational from register state |
| evt_valid | input | 1 | Hardware event strobe |
| evt_idx | input | 5 | Top-level bit the event drives |
| evt_level | input | 1 | Level the event writes |
| pwr_on | input | 1 | Power-present input |
| irq | output | 1 | Interrupt output |

## Verification
The bench builds the block with `GATE_DELAY` set to 16 instead of its default of 25,000,000 cycles. With this value, the closed and reopened gate can both be seen within a few dozen cycles. The bench also covers a power drop inside the delay window and a second power rise after the gate has opened. All other parameters keep their defaults, so the summary bits stay at positions 24, 9 and 8 and polarity stays at bit 17, as the requirements state.

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
  parameter int GATE_DELAY = 25_000_000,
  parameter int POL_BIT    = 17,
  parameter int TX_BIT     = 9,
  parameter int RX_BIT     = 8,
  parameter int DMA_BIT    = 24
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [4:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic [4:0]  rd_addr,
  output logic [31:0] rd_data,
  input  logic        evt_valid,
  input  logic [4:0]  evt_idx,
  input  logic        evt_level,
  input  logic        pwr_on,
  output logic        irq
);
  localparam int CW = $clog2(GATE_DELAY + 1);
  localparam logic [4:0] A_CFG = 5'd16;

  logic [31:0] top_q, top_mask_q, core_q, core_mask_q;
  logic [31:0] dma_q, dma_mask_q, gpio_q, gpio_mask_q, cfg_q;
  logic [31:0] top_d, top_eff;
  logic        pwr_q, run_q, gate_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [31:0] pend_next(input logic [31:0] cur, input logic [1:0] grp,
                                            input logic [31:0] d);
    if (wr_en && wr_addr[4:2] == {1'b0, grp}) begin
      if (wr_addr[1:0] == 2'd1) return cur | d;
      if (wr_addr[1:0] == 2'd2) return cur & ~d;
    end
    return cur;
  endfunction

  function automatic logic mask_hit(input logic [1:0] grp);
    return wr_en && wr_addr == {1'b0, grp, 2'd3};
  endfunction

  always_comb begin
    top_d = pend_next(top_q, 2'd0, wr_data);
    if (evt_valid) top_d[evt_idx] = evt_level;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      top_q <= '0;  top_mask_q  <= '1;
      core_q <= '0; core_mask_q <= '0;
      dma_q <= '0;  dma_mask_q  <= '0;
      gpio_q <= '0; gpio_mask_q <= '0;
      cfg_q <= '0;
    end else begin
      top_q  <= top_d;
      core_q <= pend_next(core_q, 2'd1, wr_data);
      dma_q  <= pend_next(dma_q, 2'd2, wr_data);
      gpio_q <= pend_next(gpio_q, 2'd3, wr_data);
      if (mask_hit(2'd0)) top_mask_q  <= wr_data;
      if (mask_hit(2'd1)) core_mask_q <= wr_data;
      if (mask_hit(2'd2)) dma_mask_q  <= wr_data;
      if (mask_hit(2'd3)) gpio_mask_q <= wr_data;
      if (wr_en && wr_addr == A_CFG) cfg_q <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pwr_q <= 1'b0; run_q <= 1'b0; gate_q <= 1'b0; cnt_q <= '0;
    end else begin
      pwr_q <= pwr_on;
      if (pwr_on && !pwr_q) begin
        gate_q <= 1'b0;
        run_q  <= 1'b1;
        cnt_q  <= '0;
      end else if (run_q) begin
        if (cnt_q == CW'(GATE_DELAY - 1)) begin
          run_q  <= 1'b0;
          gate_q <= pwr_on;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  always_comb begin
    top_eff          = top_q;
    top_eff[TX_BIT]  = |(core_q[15:0] & ~core_mask_q[15:0]);
    top_eff[RX_BIT]  = |(core_q[31:16] & ~core_mask_q[31:16]);
    top_eff[DMA_BIT] = |(dma_q & ~dma_mask_q);
  end

  wire active = |(top_eff & ~top_mask_q);
  assign irq = gate_q & (cfg_q[POL_BIT] ? active : ~active);

  always_comb begin
    case (rd_addr)
      5'd0, 5'd1, 5'd2:    rd_data = top_eff;
      5'd3:                rd_data = top_mask_q;
      5'd4, 5'd5, 5'd6:    rd_data = core_q;
      5'd7:                rd_data = core_mask_q;
      5'd8, 5'd9, 5'd10:   rd_data = dma_q;
      5'd11:               rd_data = dma_mask_q;
      5'd12, 5'd13, 5'd14: rd_data = gpio_q;
      5'd15:               rd_data = gpio_mask_q;
      A_CFG:               rd_data = cfg_q;
      default:             rd_data = '0;
    endcase
  end
endmodule

module irq_aggregator_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [4:0]  wr_addr,
  input logic [31:0] wr_data,
  input logic        evt_valid,
  input logic [4:0]  evt_idx,
  input logic        evt_level,
  input logic        pwr_on,
  input logic        irq,
  input logic        gate_q,
  input logic [31:0] top_q,
  input logic [31:0] top_mask_q,
  input logic [31:0] core_q
);
  // R7
  closed_gate_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_q |-> !irq);
  // R7
  power_rise_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_on) |=> !gate_q);
  // R8
  power_low_keeps_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_q && !pwr_on) |=> gate_q);
  // R2
  core_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 5'd5) |=> ((core_q & $past(wr_data)) == $past(wr_data)));
  // R2
  core_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 5'd6) |=> ((core_q & $past(wr_data)) == 32'd0));
  // R2
  top_mask_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 5'd3) |=> (top_mask_q == $past(wr_data)));
  // R10
  event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |=> (top_q[$past(evt_idx)] == $past(evt_level)));
endmodule

bind irq_aggregator irq_aggregator_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .evt_valid(evt_valid), .evt_idx(evt_idx), .evt_level(evt_level), .pwr_on(pwr_on),
  .irq(irq), .gate_q(gate_q), .top_q(top_q), .top_mask_q(top_mask_q), .core_q(core_q)
);

// File: tb/test_irq_aggregator.sv
module test_irq_aggregator;
  localparam int D = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [4:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        evt_valid = 1'b0;
  logic [4:0]  evt_idx = '0;
  logic        evt_level = 1'b0;
  logic        pwr_on = 1'b0;
  logic        irq;

  irq_aggregator #(.GATE_DELAY(D)) i_irq_aggregator (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .evt_valid(evt_valid), .evt_idx(evt_idx),
    .evt_level(evt_level), .pwr_on(pwr_on), .irq(irq)
  );

  always #10 clk = ~clk;

  typedef struct {
    bit          is_irq;
    logic [4:0]  addr;
    logic [31:0] exp;
    string       req;
  } item_t;

  item_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  initial begin : monitor
    item_t it;
    logic [31:0] act;
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        it = q.pop_front();
        if (!it.is_irq) begin
          rd_addr = it.addr;
          #2 act = rd_data;
        end else begin
          #2 act = {31'd0, irq};
        end
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s: actual %h expected %h", it.req, act, it.exp);
        end
      end
    end
  end

  task automatic chk_rd(input logic [4:0] a, input logic [31:0] e, input string r);
    item_t it;
    it.is_irq = 1'b0; it.addr = a; it.exp = e; it.req = r;
    q.push_back(it);
    wait (q.size() == 0);
  endtask

  task automatic chk_irq(input logic e, input string r);
    item_t it;
    it.is_irq = 1'b1; it.addr = '0; it.exp = {31'd0, e}; it.req = r;
    q.push_back(it);
    wait (q.size() == 0);
  endtask

  task automatic op(input logic we, input logic [4:0] a, input logic [31:0] d,
                    input logic ev, input logic [4:0] idx, input logic lvl);
    @(negedge clk);
    wr_en = we; wr_addr = a; wr_data = d;
    evt_valid = ev; evt_idx = idx; evt_level = lvl;
    @(negedge clk);
    wr_en = 1'b0; evt_valid = 1'b0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    op(1'b1, a, d, 1'b0, 5'd0, 1'b0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    chk_rd(5'd3, 32'hFFFF_FFFF, "R1 top mask");
    chk_rd(5'd0, 32'h0, "R1 top pending");
    chk_rd(5'd7, 32'h0, "R1 core mask");
    chk_rd(5'd16, 32'h0, "R1 config");
    chk_irq(1'b0, "R1 irq");

    wr(5'd16, 32'h0002_0000);
    wr(5'd3, 32'h0);
    wr(5'd1, 32'h0000_0008);
    @(negedge clk); pwr_on = 1'b1;
    repeat (D - 4) @(negedge clk);
    chk_irq(1'b0, "R7 gate closed during delay");
    repeat (8) @(negedge clk);
    chk_irq(1'b1, "R7 R5 gate open with pending bit");
    wr(5'd2, 32'h0000_0008);
    chk_irq(1'b0, "R5 nothing pending");

    wr(5'd1, 32'h0000_00F0);
    chk_rd(5'd0, 32'h0000_00F0, "R2 top view");
    chk_rd(5'd1, 32'h0000_00F0, "R2 top set readback");
    chk_rd(5'd2, 32'h0000_00F0, "R2 top clear readback");
    wr(5'd2, 32'h0000_0030);
    chk_rd(5'd0, 32'h0000_00C0, "R2 clear");
    wr(5'd0, 32'h0000_FFFF);
    chk_rd(5'd0, 32'h0000_00C0, "R2 view write ignored");
    chk_rd(5'd20, 32'h0, "R2 unmapped read");
    wr(5'd2, 32'h0000_00C0);

    wr(5'd5, 32'h0000_0001);
    chk_rd(5'd0, 32'h0000_0200, "R3 tx summary");
    wr(5'd5, 32'h0001_0000);
    chk_rd(5'd0, 32'h0000_0300, "R3 tx and rx summary");
    wr(5'd7, 32'h0000_FFFF);
    chk_rd(5'd0, 32'h0000_0100, "R3 tx masked");
    chk_rd(5'd4, 32'h0001_0001, "R3 core view");
    wr(5'd6, 32'hFFFF_FFFF);
    wr(5'd7, 32'h0);
    wr(5'd1, 32'h0000_0300);
    chk_rd(5'd0, 32'h0, "R3 summary bits ignore writes");

    wr(5'd9, 32'h0000_0004);
    chk_rd(5'd0, 32'h0100_0000, "R4 dma summary");
    wr(5'd11, 32'h0000_0004);
    chk_rd(5'd0, 32'h0, "R4 dma masked");
    chk_rd(5'd8, 32'h0000_0004, "R4 dma view");
    wr(5'd10, 32'hFFFF_FFFF);

    op(1'b0, 5'd0, 32'h0, 1'b1, 5'd5, 1'b1);
    chk_rd(5'd0, 32'h0000_0020, "R9 event sets");
    op(1'b0, 5'd0, 32'h0, 1'b1, 5'd5, 1'b0);
    chk_rd(5'd0, 32'h0, "R9 event clears");
    wr(5'd1, 32'h0000_0040);
    op(1'b1, 5'd2, 32'h0000_0040, 1'b1, 5'd6, 1'b1);
    chk_rd(5'd0, 32'h0000_0040, "R10 event beats clear");
    op(1'b1, 5'd1, 32'h0000_0080, 1'b1, 5'd7, 1'b0);
    chk_rd(5'd0, 32'h0000_0040, "R10 event beats set");
    wr(5'd2, 32'hFFFF_FFFF);

    wr(5'd16, 32'h0);
    chk_irq(1'b1, "R6 idle active high");
    wr(5'd1, 32'h0000_0001);
    chk_irq(1'b0, "R6 pending pulls low");
    wr(5'd3, 32'h0000_0001);
    chk_irq(1'b1, "R6 masked pending");
    wr(5'd3, 32'h0);
    wr(5'd2, 32'h0000_0001);
    wr(5'd16, 32'h0002_0000);

    wr(5'd13, 32'h0000_00FF);
    chk_rd(5'd12, 32'h0000_00FF, "R11 gpio view");
    chk_rd(5'd14, 32'h0000_00FF, "R11 gpio clear readback");
    wr(5'd15, 32'h0000_000F);
    chk_rd(5'd15, 32'h0000_000F, "R11 gpio mask");
    chk_irq(1'b0, "R11 gpio no irq");
    chk_rd(5'd0, 32'h0, "R11 top untouched");

    wr(5'd1, 32'h0000_0004);
    chk_irq(1'b1, "R8 pre power off");
    @(negedge clk); pwr_on = 1'b0;
    repeat (3) @(negedge clk);
    chk_irq(1'b1, "R8 power off keeps gate");
    @(negedge clk); pwr_on = 1'b1;
    repeat (3) @(negedge clk);
    chk_irq(1'b0, "R7 second rise closes");
    pwr_on = 1'b0;
    repeat (D + 6) @(negedge clk);
    chk_irq(1'b0, "R8 power lost in delay");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule